// File: doc/BRIEF.md
# E3 Transmit Overhead Inserter

This block sits in the serial transmit path of an E3 framer and writes the frame overhead into a stream of 1536-bit frames. A position counter advances on each accepted input bit and follows where the stream is in the frame. The first ten bits of every frame are replaced with the alignment word. When parity insertion is on, the last four bits of a frame carry a 4-bit interleaved parity. This parity covers the whole of the frame sent just before. All other bits pass through with one clock of latency.

For far-end testing, software can corrupt the overhead on purpose through a small write port. An XOR mask applies to the alignment word and a second XOR mask applies to the parity nibble. Masks and the enable are held in shadow registers. They are copied to the active set as the first bit of a frame is accepted, so a frame is never sent with a mix of old and new settings.

Top module: `e3_tx_ovh`

## Requirements
- R1: The frame position advances only on cycles with `din_vld_i` high and wraps after bit 1536. `sof_o` is high for exactly the one cycle that follows acceptance of frame bit 1, and is low otherwise.
- R2: Frame bits 1..10 are sent as 1111010000 (bit 1 first), each XORed with a 10-bit mask. Register address 1, data bits [4:0], masks frame bits 1..5, with data bit 4 on frame bit 1. Register address 2, data bits [4:0], masks frame bits 6..10, with data bit 4 on frame bit 6.
- R3: Every other accepted bit appears on `dout_o` unchanged one clock after acceptance. `dout_o` holds its value on cycles without `din_vld_i`.
- R4: When the enable (register address 0, data bit 7) is 1, frame bits 1533+k (k = 0..3) carry parity bit k of the previous frame. Parity bit k is the XOR of every transmitted bit n of that frame with (n-1) mod 4 = k. This covers all 1536 bits as sent, including masked overhead and the frame's own nibble.
- R5: Bit k of the parity mask (register address 3, data bits [3:0]) is XORed into the inserted parity bit k.
- R6: The first frame after reset sends the parity mask itself as its nibble, because no earlier frame exists.
- R7: With the enable at 0, bits 1533..1536 carry input data unchanged.
- R8: Register writes take effect from the next frame start. A write in the same cycle as acceptance of frame bit 1 applies only from the frame after that.
- R9: After reset, masks and enable are 0, and `dout_o` and `sof_o` are 0.
- R10: Data bits 7..5 of addresses 1 and 2, bits 7..4 of address 3 and bits 6..0 of address 0 have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| din_i | input | 1 | Serial payload bit |
| din_vld_i | input | 1 | Input bit is valid and advances the frame |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 config, 1 alignment mask upper, 2 alignment mask lower, 3 parity mask |
| wr_data_i | input | 8 | Register write data |
| dout_o | output | 1 | Serial output bit |
| sof_o | output | 1 | Pulse following acceptance of frame bit 1 |

## Verification
A register write can land in the same cycle that frame bit 1 is accepted. In that cycle the write, the frame-start copy of shadow to active settings, and the parity latch all happen on one edge. The bench sweeps the 1024 alignment mask values and pairs each with a parity mask. It places the writes at a different offset in each frame, with random gaps in the valid strobe, so the write regularly meets the frame boundary. It then checks every output bit against a bench model in which the boundary takes the old settings and the write counts only from the following frame.

// File: rtl/e3_tx_ovh_pkg.sv
package e3_tx_ovh_pkg;
  localparam int unsigned FAS_LEN   = 10;
  localparam int unsigned FAS_HALF  = FAS_LEN / 2;
  localparam logic [FAS_LEN-1:0] FAS_WORD = 10'b1111010000;
  localparam int unsigned BIP_W     = 4;
  localparam int unsigned CFG_EN_BIT = 7;

  typedef enum logic [1:0] {
    REG_CFG    = 2'd0,
    REG_FAS_HI = 2'd1,
    REG_FAS_LO = 2'd2,
    REG_BIP    = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic               par_en;
    logic [FAS_LEN-1:0] fas_mask;
    logic [BIP_W-1:0]   bip_mask;
  } ovh_cfg_t;
endpackage

// File: rtl/e3_pos_ctr.sv
module e3_pos_ctr #(
  parameter int unsigned FRAME_BITS = 1536,
  localparam int unsigned POS_W = $clog2(FRAME_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [POS_W-1:0] pos_o
);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pos_o <= '0;
    else if (adv_i)    pos_o <= (pos_o == LAST) ? '0 : pos_o + 1'b1;
  end
endmodule

// File: rtl/e3_ovh_regs.sv
module e3_ovh_regs
  import e3_tx_ovh_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_en_i,
  input  logic [1:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic     load_i,
  output ovh_cfg_t shadow_o,
  output ovh_cfg_t active_o
);
  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data_i[6:5];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_o <= '0;
    end else if (wr_en_i) begin
      case (reg_addr_e'(wr_addr_i))
        REG_CFG:    shadow_o.par_en <= wr_data_i[CFG_EN_BIT];
        REG_FAS_HI: shadow_o.fas_mask[FAS_LEN-1:FAS_HALF] <= wr_data_i[FAS_HALF-1:0];
        REG_FAS_LO: shadow_o.fas_mask[FAS_HALF-1:0] <= wr_data_i[FAS_HALF-1:0];
        REG_BIP:    shadow_o.bip_mask <= wr_data_i[BIP_W-1:0];
        default:    ;
      endcase
    end
  end

  // active copy only moves at a frame start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     active_o <= '0;
    else if (load_i) active_o <= shadow_o;
  end
endmodule

// File: rtl/e3_bip_acc.sv
module e3_bip_acc #(
  parameter int unsigned LANES = 4,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              frame_start_i,
  input  logic              bit_i,
  input  logic [LANE_W-1:0] lane_i,
  output logic [LANES-1:0]  held_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic acc_q;
    logic held_q;
    logic hit;
    assign hit = (lane_i == LANE_W'(k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_q  <= 1'b0;
        held_q <= 1'b0;
      end else if (adv_i) begin
        if (frame_start_i) begin
          held_q <= acc_q;
          acc_q  <= hit & bit_i;
        end else if (hit) begin
          acc_q  <= acc_q ^ bit_i;
        end
      end
    end

    assign held_o[k] = held_q;
  end
endmodule

// File: rtl/e3_ovh_mux.sv
module e3_ovh_mux
  import e3_tx_ovh_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 1536,
  localparam int unsigned POS_W = $clog2(FRAME_BITS),
  localparam int unsigned NIB_START = FRAME_BITS - BIP_W
) (
  input  logic [POS_W-1:0] pos_i,
  input  logic             din_i,
  input  ovh_cfg_t         cfg_i,
  input  logic [BIP_W-1:0] held_i,
  output logic             bit_o
);
  always_comb begin
    bit_o = din_i;
    for (int i = 0; i < int'(FAS_LEN); i++) begin
      if (pos_i == POS_W'(i))
        bit_o = FAS_WORD[FAS_LEN-1-i] ^ cfg_i.fas_mask[FAS_LEN-1-i];
    end
    if (cfg_i.par_en) begin
      for (int k = 0; k < int'(BIP_W); k++) begin
        if (pos_i == POS_W'(NIB_START + k))
          bit_o = held_i[k] ^ cfg_i.bip_mask[k];
      end
    end
  end
endmodule

// File: rtl/e3_tx_ovh.sv
module e3_tx_ovh
  import e3_tx_ovh_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 1536
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       din_i,
  input  logic       din_vld_i,
  input  logic       wr_en_i,
  input  logic [1:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  output logic       dout_o,
  output logic       sof_o
);
  localparam int unsigned POS_W  = $clog2(FRAME_BITS);
  localparam int unsigned LANE_W = $clog2(BIP_W);

  logic [POS_W-1:0] pos_q;
  logic             frame_start;
  logic             load;
  ovh_cfg_t         cfg_shadow, cfg_active, cfg_eff;
  logic             par_en_q;
  logic [BIP_W-1:0] bip_held;
  logic             tx_bit;

  e3_pos_ctr #(.FRAME_BITS(FRAME_BITS)) u_pos (
    .clk_i (clk_i), .rst_ni(rst_ni), .adv_i(din_vld_i), .pos_o(pos_q)
  );

  assign frame_start = (pos_q == '0);
  assign load        = din_vld_i & frame_start;

  e3_ovh_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .load_i   (load),
    .shadow_o (cfg_shadow),
    .active_o (cfg_active)
  );

  // bit 1 already uses the settings being loaded
  assign cfg_eff  = frame_start ? cfg_shadow : cfg_active;
  assign par_en_q = cfg_active.par_en;

  e3_ovh_mux #(.FRAME_BITS(FRAME_BITS)) u_mux (
    .pos_i (pos_q),
    .din_i (din_i),
    .cfg_i (cfg_eff),
    .held_i(bip_held),
    .bit_o (tx_bit)
  );

  e3_bip_acc #(.LANES(BIP_W)) u_bip (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .adv_i        (din_vld_i),
    .frame_start_i(frame_start),
    .bit_i        (tx_bit),
    .lane_i       (pos_q[LANE_W-1:0]),
    .held_o       (bip_held)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_o <= 1'b0;
      sof_o  <= 1'b0;
    end else begin
      sof_o <= load;
      if (din_vld_i) dout_o <= tx_bit;
    end
  end
endmodule

// File: rtl/e3_tx_ovh_chk.sv
module e3_tx_ovh_chk
  import e3_tx_ovh_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 1536,
  localparam int unsigned POS_W = $clog2(FRAME_BITS),
  localparam int unsigned NIB_START = FRAME_BITS - BIP_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             din_i,
  input logic             din_vld_i,
  input logic             dout_o,
  input logic             sof_o,
  input logic [POS_W-1:0] pos_i,
  input logic             en_i
);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS - 1);

  p_pos_adv_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    din_vld_i |=> pos_i == (($past(pos_i) == LAST) ? '0 : $past(pos_i) + 1'b1));

  p_pos_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !din_vld_i |=> $stable(pos_i));

  p_sof_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (din_vld_i && pos_i == '0) |=> sof_o);

  p_sof_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |=> !sof_o);

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !din_vld_i |=> ($stable(dout_o) && !sof_o));

  // R3 payload and R7 disabled nibble pass through
  p_pass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (din_vld_i && pos_i >= POS_W'(FAS_LEN) && (pos_i < POS_W'(NIB_START) || !en_i))
    |=> dout_o == $past(din_i));
endmodule

bind e3_tx_ovh e3_tx_ovh_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .din_i    (din_i),
  .din_vld_i(din_vld_i),
  .dout_o   (dout_o),
  .sof_o    (sof_o),
  .pos_i    (pos_q),
  .en_i     (par_en_q)
);

// File: tb/sim_e3_tx_ovh.sv
module sim_e3_tx_ovh;
  localparam int F = 64;
  localparam logic [9:0] FAS = 10'b1111010000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic din = 1'b0, vld = 1'b0, we = 1'b0;
  logic [1:0] wa = '0;
  logic [7:0] wd = '0;
  logic dout, sof;

  e3_tx_ovh #(.FRAME_BITS(F)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .din_i(din), .din_vld_i(vld),
    .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
    .dout_o(dout), .sof_o(sof)
  );

  always #4 clk = ~clk; // 8 ns period, 125 MHz

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // bench model
  int mpos = 0, mframe = 0;
  bit sh_en = 0, act_en = 0;
  logic [9:0] sh_fm = '0, act_fm = '0;
  logic [3:0] sh_bm = '0, act_bm = '0, macc = '0, mheld = '0;
  logic exp_d = 1'b0, exp_s = 1'b0;
  string exp_tag = "R9", ovr = "";
  bit r8_pend = 0, r8_frame = 0;

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b (frame %0d pos %0d)", tag, act, exp, mframe, mpos);
    end
  endtask

  task automatic step(bit v, bit b, bit w, logic [1:0] a, logic [7:0] d);
    logic e;
    string t;
    @(negedge clk);
    chk(exp_tag, dout, exp_d);
    chk("R1", sof, exp_s);
    vld = v; din = b; we = w; wa = a; wd = d;
    if (v) begin
      if (mpos == 0) begin
        act_en = sh_en; act_fm = sh_fm; act_bm = sh_bm;
        mheld = macc; macc = '0; mframe++;
        r8_frame = r8_pend; r8_pend = (w == 1'b1);
      end
      if (mpos < 10) begin
        e = FAS[9-mpos] ^ act_fm[9-mpos];
        t = r8_frame ? "R8" : "R2";
      end else if (act_en && mpos >= F-4) begin
        e = mheld[mpos-(F-4)] ^ act_bm[mpos-(F-4)];
        t = (mframe == 1) ? "R6" : "R4 R5";
      end else begin
        e = b;
        t = (mpos >= F-4) ? "R7" : "R3";
      end
      if (ovr != "") t = ovr;
      macc[mpos % 4] = macc[mpos % 4] ^ e;
      exp_d = e; exp_s = (mpos == 0); exp_tag = t;
      mpos = (mpos + 1) % F;
    end else begin
      exp_s = 1'b0;
      exp_tag = "R3";
    end
    if (w) begin
      case (a)
        2'd0: sh_en = d[7];
        2'd1: sh_fm[9:5] = d[4:0];
        2'd2: sh_fm[4:0] = d[4:0];
        default: sh_bm = d[3:0];
      endcase
    end
  endtask

  task automatic run(int n, int gap_mod);
    for (int i = 0; i < n; i++)
      step((gap_mod == 0) || ($urandom % gap_mod != 0), 1'($urandom), 0, 2'd0, 8'h00);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) step(0, 0, 0, 2'd0, 8'h00); // R9 reset state
    rst_n = 1'b1;
    step(0, 0, 0, 2'd0, 8'h00);
    // R6: enable and parity mask before first frame
    step(0, 0, 1, 2'd0, 8'h80);
    step(0, 0, 1, 2'd3, 8'h0A);
    run(3 * F, 0);
    step(1, 1, 1, 2'd3, 8'h05);
    run(2 * F, 5);
    step(1, 0, 1, 2'd0, 8'h00);
    run(3 * F, 0); // R7 disabled nibble
    // R10: only unused bits written
    ovr = "R10";
    step(1, 1, 1, 2'd0, 8'hFF);
    step(1, 0, 1, 2'd1, 8'hE0);
    step(1, 1, 1, 2'd2, 8'hE0);
    step(1, 0, 1, 2'd3, 8'hF0);
    run(3 * F, 0);
    ovr = "";
    // sweep of alignment masks with parity masks, writes at shifting offsets
    for (int m = 0; m < 1024; m++) begin
      int off = m % F;
      logic [9:0] mv = 10'(m);
      for (int c = 0; c < F + 2; c++) begin
        if (c == off)
          step(1, 1'($urandom), 1, 2'd1, {3'($urandom), mv[9:5]});
        else if (c == off + 1)
          step(1, 1'($urandom), 1, 2'd2, {3'($urandom), mv[4:0]});
        else if (c == off + 2)
          step(($urandom % 7) != 0, 1'($urandom), 1, 2'd3, {4'($urandom), mv[3:0] ^ mv[9:6]});
        else
          step(($urandom % 7) != 0, 1'($urandom), 0, 2'd0, 8'h00);
      end
    end
    run(2 * F, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule